// File: doc/BRIEF.md
# Sensor Array Column Scan and Calibration Sequencer

This block drives the digital switch controls of a current-mode sensor pixel array that is read one column at a time. In each column time slot it closes exactly one column select. All rows of that column are handled in parallel, either in a calibration phase or in a readout phase. A calibration pass visits every column of the array in ascending order. For each column it closes the select, then closes the two calibration switches: the one that diode-connects the sensor transistor and the one for the amplifier's common-mode bias branch. It opens the calibration switches again while the select is still closed, so the stored gate voltage is held.

Readout frames follow the calibration pass. In a readout frame the row-line hold switch is closed, and each column slot is split into a settling window followed by a series of sub-slots. During each sub-slot the output multiplexer select picks one group of row amplifiers, and a one-cycle sample strobe marks the sampling point. A programmable count of readout frames sets how often the calibration pass repeats. A rectangular region of interest can limit readout to a window of columns and multiplexer groups, which shortens the frame and raises the frame rate. Timing values and the window are written through a small write port into shadow registers. The block loads them into its working copy only at a pass boundary.

Top module: `scan_cal_sequencer`

## Requirements
- R1: `colSel` never has more than one bit set. While a pass runs exactly one bit is set, and within a pass the selected column index only rises.
- R2: A calibration pass covers columns 0 to NUM_COLS-1 whatever the region of interest. Each column takes calLen+2 cycles: one cycle with the select only, calLen cycles with `calSw` and `cmCalSw` both closed, then one cycle with the select only.
- R3: When `run` is seen high while idle, a calibration pass is produced before any readout frame. `calActive` is high for every cycle of a calibration pass and low in readout.
- R4: `calSw` closes only in a cycle after the same column select has already been closed. It opens while that select is still closed.
- R5: In readout `holdSw` is closed and `calSw` is open. A column slot lasts settleLen + nSub*subLen cycles. During the first settleLen cycles `muxSel` is 0 and no strobe is given.
- R6: After settling, `muxSel` steps from the window's first group to its last group, and each value is held subLen cycles. `sampleStb` is high in the last cycle of each sub-slot. Outside sub-slots `muxSel` is 0.
- R7: After framesPerCal readout frames a calibration pass follows. A framesPerCal of 0 acts as 1.
- R8: Write addresses: 0 settleLen, 1 subLen, 2 calLen, 3 framesPerCal, 4 column window, 5 group window. A write to addresses 6 and 7 has no effect. A length of 0 acts as 1.
- R9: A write changes the timing only from the next pass boundary, meaning the start of a calibration pass or of a readout frame.
- R10: In the column window, bits [COL_W-1:0] hold the first column and bits [2*COL_W-1:COL_W] hold the last column. In the group window, bits [SUB_W-1:0] hold the first group and bits [2*SUB_W-1:SUB_W] hold the last group. If first > last or last is out of range, the full range is used.
- R11: `frameStart` is high for one cycle, the first cycle of each readout frame.
- R12: A synchronous reset opens every switch, clears all status outputs, restores the default settings and leaves the block idle. If `run` is low at a pass boundary, the block returns to idle with all switches open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enable scanning; sampled when idle and at pass boundaries |
| wrEn | input | 1 | Setting write strobe |
| wrAddr | input | 3 | Setting address |
| wrData | input | DATA_W | Setting value |
| colSel | output | NUM_COLS | One-hot column select switches |
| calSw | output | 1 | Sensor calibration (diode) switch |
| cmCalSw | output | 1 | Common-mode bias branch calibration switch |
| holdSw | output | 1 | Row-line voltage hold switch |
| muxSel | output | clog2(MUX_WAYS) | Output multiplexer group select |
| sampleStb | output | 1 | One-cycle sample strobe per sub-slot |
| frameStart | output | 1 | First cycle of a readout frame |
| calActive | output | 1 | Calibration pass in progress |

## Verification
The bench builds the block with six columns, four multiplexer groups and small default lengths. A calibration pass then takes a few tens of cycles and a readout frame under a hundred. Each sweep covers many alternations between calibration passes and readout frames, several region-of-interest shapes, invalid windows, zero-valued lengths and frame counts, and settings written in the middle of a pass. Every output is compared on every cycle with a pass-by-pass schedule computed in the bench, including restarts after idle and after a reset in the middle of a pass.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_PRE,
    ST_CAL_HOLD,
    ST_CAL_POST,
    ST_RD_SETTLE,
    ST_RD_SUB
  } scan_state_e;

  // strobes from the sequencer to the counters and output decode
  typedef struct packed {
    logic cfgLoad;
    logic cycClr;
    logic colToZero;
    logic colToLo;
    logic colInc;
    logic subToLo;
    logic subInc;
    logic frmClr;
    logic frmInc;
    logic selOn;
    logic calOn;
    logic holdOn;
    logic subOn;
  } scan_cmd_t;

  // status from the counters back to the sequencer
  typedef struct packed {
    logic settleDone;
    logic subDone;
    logic holdDone;
    logic lastCalCol;
    logic lastRdCol;
    logic lastSub;
    logic calDue;
  } scan_flag_t;

  localparam logic [2:0] ADDR_SETTLE = 3'd0;
  localparam logic [2:0] ADDR_SUB    = 3'd1;
  localparam logic [2:0] ADDR_CAL    = 3'd2;
  localparam logic [2:0] ADDR_FPC    = 3'd3;
  localparam logic [2:0] ADDR_COLWIN = 3'd4;
  localparam logic [2:0] ADDR_SUBWIN = 3'd5;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  scan_flag_t flags,
  output scan_cmd_t  cmd
);

  scan_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        cmd.cycClr = 1'b1;
        if (run) begin
          cmd.cfgLoad   = 1'b1;
          cmd.colToZero = 1'b1;
          stateNext     = ST_CAL_PRE;
        end
      end
      ST_CAL_PRE: begin
        cmd.selOn  = 1'b1;
        cmd.cycClr = 1'b1;
        stateNext  = ST_CAL_HOLD;
      end
      ST_CAL_HOLD: begin
        cmd.selOn = 1'b1;
        cmd.calOn = 1'b1;
        if (flags.holdDone) begin
          cmd.cycClr = 1'b1;
          stateNext  = ST_CAL_POST;
        end
      end
      ST_CAL_POST: begin
        cmd.selOn  = 1'b1;
        cmd.cycClr = 1'b1;
        if (flags.lastCalCol) begin
          cmd.frmClr = 1'b1;
          if (run) begin
            cmd.cfgLoad = 1'b1;
            cmd.colToLo = 1'b1;
            stateNext   = ST_RD_SETTLE;
          end else begin
            stateNext = ST_IDLE;
          end
        end else begin
          cmd.colInc = 1'b1;
          stateNext  = ST_CAL_PRE;
        end
      end
      ST_RD_SETTLE: begin
        cmd.selOn  = 1'b1;
        cmd.holdOn = 1'b1;
        if (flags.settleDone) begin
          cmd.cycClr  = 1'b1;
          cmd.subToLo = 1'b1;
          stateNext   = ST_RD_SUB;
        end
      end
      ST_RD_SUB: begin
        cmd.selOn  = 1'b1;
        cmd.holdOn = 1'b1;
        cmd.subOn  = 1'b1;
        if (flags.subDone) begin
          cmd.cycClr = 1'b1;
          if (!flags.lastSub) begin
            cmd.subInc = 1'b1;
          end else if (!flags.lastRdCol) begin
            cmd.colInc = 1'b1;
            stateNext  = ST_RD_SETTLE;
          end else begin
            cmd.frmInc = 1'b1;
            if (!run) begin
              stateNext = ST_IDLE;
            end else if (flags.calDue) begin
              cmd.cfgLoad   = 1'b1;
              cmd.colToZero = 1'b1;
              stateNext     = ST_CAL_PRE;
            end else begin
              cmd.cfgLoad = 1'b1;
              cmd.colToLo = 1'b1;
              stateNext   = ST_RD_SETTLE;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_COLS   = 128,
  parameter int MUX_WAYS   = 8,
  parameter int DATA_W     = 16,
  parameter int DEF_SETTLE = 64,
  parameter int DEF_SUB    = 8,
  parameter int DEF_CAL    = 32,
  parameter int DEF_FPC    = 100
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wrEn,
  input  logic [2:0]                  wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  scan_cmd_t                   cmd,
  output scan_flag_t                  flags,
  output logic [NUM_COLS-1:0]         colSel,
  output logic                        calSw,
  output logic                        cmCalSw,
  output logic                        holdSw,
  output logic [$clog2(MUX_WAYS)-1:0] muxSel,
  output logic                        sampleStb,
  output logic                        frameStart,
  output logic                        calActive
);

  localparam int COL_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int SUB_W = $clog2(MUX_WAYS);
  localparam logic [COL_W-1:0]  COL_MAX = COL_W'(NUM_COLS - 1);
  localparam logic [SUB_W-1:0]  SUB_MAX = SUB_W'(MUX_WAYS - 1);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

  function automatic logic [DATA_W-1:0] atLeastOne(input logic [DATA_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  // shadow settings, written at any time
  logic [DATA_W-1:0]  shSettle, shSub, shCal, shFpc;
  logic [2*COL_W-1:0] shColWin;
  logic [2*SUB_W-1:0] shSubWin;

  // working settings, loaded at pass boundaries
  logic [DATA_W-1:0]  actSettle, actSub, actCal, actFpc;
  logic [COL_W-1:0]   actColLo, actColHi;
  logic [SUB_W-1:0]   actSubLo, actSubHi;

  // counters
  logic [DATA_W-1:0]  cycCnt;
  logic [DATA_W-1:0]  frmCnt;
  logic [COL_W-1:0]   col;
  logic [SUB_W-1:0]   sub;

  // sanitized windows from the shadow copy
  logic [COL_W-1:0]   newColLo, newColHi, rawColLo, rawColHi;
  logic [SUB_W-1:0]   newSubLo, newSubHi, rawSubLo, rawSubHi;
  logic               colWinOk, subWinOk;

  always_comb begin
    rawColLo = shColWin[COL_W-1:0];
    rawColHi = shColWin[2*COL_W-1:COL_W];
    colWinOk = (rawColLo <= rawColHi) && (int'(rawColHi) < NUM_COLS);
    newColLo = colWinOk ? rawColLo : '0;
    newColHi = colWinOk ? rawColHi : COL_MAX;
    rawSubLo = shSubWin[SUB_W-1:0];
    rawSubHi = shSubWin[2*SUB_W-1:SUB_W];
    subWinOk = (rawSubLo <= rawSubHi) && (int'(rawSubHi) < MUX_WAYS);
    newSubLo = subWinOk ? rawSubLo : '0;
    newSubHi = subWinOk ? rawSubHi : SUB_MAX;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shSettle <= DATA_W'(DEF_SETTLE);
      shSub    <= DATA_W'(DEF_SUB);
      shCal    <= DATA_W'(DEF_CAL);
      shFpc    <= DATA_W'(DEF_FPC);
      shColWin <= {COL_MAX, COL_W'(0)};
      shSubWin <= {SUB_MAX, SUB_W'(0)};
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_SETTLE: shSettle <= wrData;
        ADDR_SUB:    shSub    <= wrData;
        ADDR_CAL:    shCal    <= wrData;
        ADDR_FPC:    shFpc    <= wrData;
        ADDR_COLWIN: shColWin <= wrData[2*COL_W-1:0];
        ADDR_SUBWIN: shSubWin <= wrData[2*SUB_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      actSettle <= atLeastOne(DATA_W'(DEF_SETTLE));
      actSub    <= atLeastOne(DATA_W'(DEF_SUB));
      actCal    <= atLeastOne(DATA_W'(DEF_CAL));
      actFpc    <= atLeastOne(DATA_W'(DEF_FPC));
      actColLo  <= '0;
      actColHi  <= COL_MAX;
      actSubLo  <= '0;
      actSubHi  <= SUB_MAX;
    end else if (cmd.cfgLoad) begin
      actSettle <= atLeastOne(shSettle);
      actSub    <= atLeastOne(shSub);
      actCal    <= atLeastOne(shCal);
      actFpc    <= atLeastOne(shFpc);
      actColLo  <= newColLo;
      actColHi  <= newColHi;
      actSubLo  <= newSubLo;
      actSubHi  <= newSubHi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cycCnt <= '0;
      frmCnt <= '0;
      col    <= '0;
      sub    <= '0;
    end else begin
      cycCnt <= cmd.cycClr ? '0 : cycCnt + ONE;

      if (cmd.frmClr)      frmCnt <= '0;
      else if (cmd.frmInc) frmCnt <= frmCnt + ONE;

      if (cmd.colToZero)    col <= '0;
      else if (cmd.colToLo) col <= cmd.cfgLoad ? newColLo : actColLo;
      else if (cmd.colInc)  col <= col + COL_W'(1);

      if (cmd.subToLo)     sub <= actSubLo;
      else if (cmd.subInc) sub <= sub + SUB_W'(1);
    end
  end

  always_comb begin
    flags.settleDone = (cycCnt == actSettle - ONE);
    flags.subDone    = (cycCnt == actSub - ONE);
    flags.holdDone   = (cycCnt == actCal - ONE);
    flags.lastCalCol = (col == COL_MAX);
    flags.lastRdCol  = (col == actColHi);
    flags.lastSub    = (sub == actSubHi);
    flags.calDue     = ({1'b0, frmCnt} + {{DATA_W{1'b0}}, 1'b1}) >= {1'b0, actFpc};
  end

  // one select line per column
  for (genvar i = 0; i < NUM_COLS; i++) begin : g_colSel
    assign colSel[i] = cmd.selOn && (col == COL_W'(i));
  end

  assign calSw      = cmd.calOn;
  assign cmCalSw    = cmd.calOn;
  assign holdSw     = cmd.holdOn;
  assign calActive  = cmd.selOn && !cmd.holdOn;
  assign muxSel     = cmd.subOn ? sub : '0;
  assign sampleStb  = cmd.subOn && flags.subDone;
  assign frameStart = cmd.holdOn && !cmd.subOn && (cycCnt == '0) && (col == actColLo);

endmodule

// File: rtl/scan_cal_sequencer.sv
module scan_cal_sequencer
  import scan_pkg::*;
#(
  parameter int NUM_COLS   = 128,
  parameter int MUX_WAYS   = 8,
  parameter int DATA_W     = 16,
  parameter int DEF_SETTLE = 64,
  parameter int DEF_SUB    = 8,
  parameter int DEF_CAL    = 32,
  parameter int DEF_FPC    = 100
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run,
  input  logic                        wrEn,
  input  logic [2:0]                  wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  output logic [NUM_COLS-1:0]         colSel,
  output logic                        calSw,
  output logic                        cmCalSw,
  output logic                        holdSw,
  output logic [$clog2(MUX_WAYS)-1:0] muxSel,
  output logic                        sampleStb,
  output logic                        frameStart,
  output logic                        calActive
);

  scan_cmd_t  cmd;
  scan_flag_t flags;

  scan_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .flags (flags),
    .cmd   (cmd)
  );

  scan_datapath #(
    .NUM_COLS   (NUM_COLS),
    .MUX_WAYS   (MUX_WAYS),
    .DATA_W     (DATA_W),
    .DEF_SETTLE (DEF_SETTLE),
    .DEF_SUB    (DEF_SUB),
    .DEF_CAL    (DEF_CAL),
    .DEF_FPC    (DEF_FPC)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .cmd        (cmd),
    .flags      (flags),
    .colSel     (colSel),
    .calSw      (calSw),
    .cmCalSw    (cmCalSw),
    .holdSw     (holdSw),
    .muxSel     (muxSel),
    .sampleStb  (sampleStb),
    .frameStart (frameStart),
    .calActive  (calActive)
  );

endmodule

// File: rtl/scan_cal_sequencer_chk.sv
module scan_cal_sequencer_chk #(
  parameter int NUM_COLS = 128
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_COLS-1:0] colSel,
  input logic                calSw,
  input logic                cmCalSw,
  input logic                holdSw,
  input logic                sampleStb,
  input logic                frameStart,
  input logic                calActive
);

  AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(colSel)); // R1

  AST_CAL_AFTER_SELECT: assert property (@(posedge clk) disable iff (rst)
    ($rose(calSw) || $rose(cmCalSw)) |-> ($stable(colSel) && (colSel != '0))); // R4

  AST_SELECT_OUTLASTS_CAL: assert property (@(posedge clk) disable iff (rst)
    $fell(calSw) |-> ($stable(colSel) && (colSel != '0))); // R4

  AST_CAL_HOLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(calSw && holdSw)); // R5

  AST_CAL_IN_CAL_PASS: assert property (@(posedge clk) disable iff (rst)
    calSw |-> calActive); // R2

  AST_STROBE_IN_READOUT: assert property (@(posedge clk) disable iff (rst)
    sampleStb |-> (holdSw && !calActive && (colSel != '0))); // R6

  AST_FRAME_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart); // R11

endmodule

bind scan_cal_sequencer scan_cal_sequencer_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .colSel     (colSel),
  .calSw      (calSw),
  .cmCalSw    (cmCalSw),
  .holdSw     (holdSw),
  .sampleStb  (sampleStb),
  .frameStart (frameStart),
  .calActive  (calActive)
);

// File: tb/scan_cal_sequencer_bench.sv
module scan_cal_sequencer_bench;

  localparam int NC    = 6;
  localparam int MW    = 4;
  localparam int DW    = 16;
  localparam int COL_W = $clog2(NC);
  localparam int SUB_W = $clog2(MW);
  localparam int D_SET = 4;
  localparam int D_SUB = 1;
  localparam int D_CAL = 3;
  localparam int D_FPC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [NC-1:0] colSel;
  logic calSw, cmCalSw, holdSw, sampleStb, frameStart, calActive;
  logic [SUB_W-1:0] muxSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scan_cal_sequencer #(
    .NUM_COLS(NC), .MUX_WAYS(MW), .DATA_W(DW),
    .DEF_SETTLE(D_SET), .DEF_SUB(D_SUB), .DEF_CAL(D_CAL), .DEF_FPC(D_FPC)
  ) u_scan_cal_sequencer (
    .clk(clk), .rst(rst), .run(run), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .colSel(colSel), .calSw(calSw), .cmCalSw(cmCalSw), .holdSw(holdSw),
    .muxSel(muxSel), .sampleStb(sampleStb), .frameStart(frameStart), .calActive(calActive)
  );

  // bench model of the settings and the pass schedule
  int shS, shU, shC, shF, shCW, shSW;
  int aS, aU, aC, aF, aCLo, aCHi, aSLo, aSHi;
  int inCal, off, rdCount;

  function automatic int max1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic modelDefaults();
    shS = D_SET; shU = D_SUB; shC = D_CAL; shF = D_FPC;
    shCW = 0 | ((NC - 1) << COL_W);
    shSW = 0 | ((MW - 1) << SUB_W);
  endtask

  task automatic modelLoad();
    int lo, hi;
    aS = max1(shS); aU = max1(shU); aC = max1(shC); aF = max1(shF);
    lo = shCW & ((1 << COL_W) - 1);
    hi = (shCW >> COL_W) & ((1 << COL_W) - 1);
    if (lo <= hi && hi < NC) begin aCLo = lo; aCHi = hi; end
    else begin aCLo = 0; aCHi = NC - 1; end
    lo = shSW & ((1 << SUB_W) - 1);
    hi = (shSW >> SUB_W) & ((1 << SUB_W) - 1);
    if (lo <= hi && hi < MW) begin aSLo = lo; aSHi = hi; end
    else begin aSLo = 0; aSHi = MW - 1; end
  endtask

  // R8: addresses 0..5 map to settings, 6 and 7 are ignored
  task automatic modelWrite(input int a, input int d);
    case (a)
      0: shS = d;
      1: shU = d;
      2: shC = d;
      3: shF = d;
      4: shCW = d & ((1 << (2 * COL_W)) - 1);
      5: shSW = d & ((1 << (2 * SUB_W)) - 1);
      default: ;
    endcase
  endtask

  function automatic int passLen();
    if (inCal != 0) return NC * (aC + 2);
    return (aCHi - aCLo + 1) * (aS + (aSHi - aSLo + 1) * aU);
  endfunction

  task automatic chk(input string tag, input string what, input int t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%0d expected=%0d", tag, what, t, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    chk(tag, "R12 colSel", -1, int'(colSel), 0);
    chk(tag, "R12 calSw", -1, int'(calSw), 0);
    chk(tag, "R12 cmCalSw", -1, int'(cmCalSw), 0);
    chk(tag, "R12 holdSw", -1, int'(holdSw), 0);
    chk(tag, "R12 muxSel", -1, int'(muxSel), 0);
    chk(tag, "R12 sampleStb", -1, int'(sampleStb), 0);
    chk(tag, "R12 frameStart", -1, int'(frameStart), 0);
    chk(tag, "R12 calActive", -1, int'(calActive), 0);
  endtask

  task automatic compareCycle(input string tag, input int t);
    int col, cal, hold, mux, stb, fs, ca, slot, u, ns;
    if (inCal != 0) begin
      col = off / (aC + 2);
      u = off % (aC + 2);
      cal = (u >= 1 && u <= aC) ? 1 : 0;
      hold = 0; mux = 0; stb = 0; fs = 0; ca = 1;
    end else begin
      ns = aSHi - aSLo + 1;
      slot = aS + ns * aU;
      col = aCLo + off / slot;
      u = off % slot;
      cal = 0; hold = 1; ca = 0;
      fs = (off == 0) ? 1 : 0;
      if (u < aS) begin
        mux = 0; stb = 0;
      end else begin
        mux = aSLo + (u - aS) / aU;
        stb = (((u - aS) % aU) == aU - 1) ? 1 : 0;
      end
    end
    chk(tag, "R1 colSel", t, int'(colSel), 1 << col);
    chk(tag, "R4 calSw", t, int'(calSw), cal);
    chk(tag, "R2 cmCalSw", t, int'(cmCalSw), cal);
    chk(tag, "R5 holdSw", t, int'(holdSw), hold);
    chk(tag, "R6 muxSel", t, int'(muxSel), mux);
    chk(tag, "R6 sampleStb", t, int'(sampleStb), stb);
    chk(tag, "R11 frameStart", t, int'(frameStart), fs);
    chk(tag, "R3 calActive", t, int'(calActive), ca);
  endtask

  // called at a falling edge with the block idle and run about to be seen
  task automatic sweep(input string tag, input int n,
                       input int wt, input int wa, input int wd,
                       input int wt2, input int wa2, input int wd2);
    run = 1'b1;
    inCal = 1; off = 0; rdCount = 0;
    modelLoad();
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      compareCycle(tag, t);
      off++;
      if (off == passLen()) begin
        if (inCal != 0) begin
          inCal = 0; rdCount = 0;
        end else begin
          rdCount++;
          if (rdCount >= aF) inCal = 1;
        end
        off = 0;
        modelLoad();
      end
      wrEn = 1'b0;
      if (t == wt) begin
        wrEn = 1'b1; wrAddr = 3'(wa); wrData = DW'(wd); modelWrite(wa, wd);
      end else if (t == wt2) begin
        wrEn = 1'b1; wrAddr = 3'(wa2); wrData = DW'(wd2); modelWrite(wa2, wd2);
      end
    end
    @(negedge clk);
    wrEn = 1'b0;
    run = 1'b0;
  endtask

  task automatic writeReg(input int a, input int d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = DW'(d);
    modelWrite(a, d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drainToIdle(input string tag);
    repeat (700) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      checkIdle(tag);
      @(negedge clk);
    end
  endtask

  initial begin
    modelDefaults();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R12: after reset everything is open and stays idle with run low
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      checkIdle("R12");
    end

    // R3 / R9: basic timing, settle length changed inside a readout frame
    writeReg(0, 3);
    writeReg(1, 2);
    writeReg(2, 2);
    writeReg(3, 2);
    sweep("R9", 420, 60, 0, 5, -1, 0, 0);
    drainToIdle("R12");

    // R10: region of interest, then an invalid column window falls back to full
    writeReg(4, 1 | (3 << COL_W));
    writeReg(5, 1 | (2 << SUB_W));
    writeReg(3, 3);
    sweep("R10", 520, 150, 4, 4 | (2 << COL_W), 330, 5, 3 | (1 << SUB_W));
    drainToIdle("R12");

    // R7, R8: zero lengths and zero frame count act as one, unused addresses ignored
    writeReg(0, 0);
    writeReg(1, 0);
    writeReg(2, 0);
    writeReg(3, 0);
    writeReg(5, 0 | (3 << SUB_W));
    writeReg(6, 9);
    writeReg(7, 0);
    sweep("R7,R8", 320, 100, 1, 3, 200, 7, 5);
    drainToIdle("R12");

    // R12: reset in the middle of a pass restores defaults and restarts with calibration
    run = 1'b1;
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checkIdle("R12");
    rst = 1'b0;
    modelDefaults();
    sweep("R12", 300, -1, 0, 0, -1, 0, 0);
    drainToIdle("R12");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule